// File: doc/BRIEF.md
# Pipelined Burst Static RAM Model

A synthesizable cycle model of a synchronous pipelined burst static RAM with 64-bit words. It is meant to sit beside a processor as a cache data store. Every synchronous input (address, write data, strobes, enables, write controls) is captured on the rising clock edge. Read data goes through an output register, so each read access shows on the data-out port one edge after its address is captured. The shared bus of a real part is split here into a data-in port, a data-out port and a data-out-enable flag.

A burst can be opened by either of two strobes. The processor-start strobe is masked by the primary chip enable and always opens with a read. The controller-start strobe is not masked. It opens a read or a write, depending on write control, and it deselects the device when the primary enable is off. After the opening beat, an internal 2-bit counter steps through a group of four words, in either linear or interleaved order. The advance input can hold the counter to insert wait states. A sleep input powers the device down at once. After sleep is released, start strobes are ignored for two clock edges.

Top module: `burst_sram_model`

## Requirements
- R1: After reset no burst is active and `rdata_oe_o` is 0. Cycles with no start strobe produce no access until a burst is opened.
- R2: While `ce_n_i` is 1, the processor-start strobe (`pstart_n_i` = 0) is ignored. A controller-start strobe (`cstart_n_i` = 0) with `ce_n_i` = 1 deselects the device and ends any running burst.
- R3: The secondary enables are sampled only at an edge that carries an accepted start strobe. The device is selected only when `sel_hi_a_i` = 1, `sel_hi_b_i` = 1, `sel_lo_a_n_i` = 0 and `sel_lo_b_n_i` = 0; otherwise that edge deselects. Their value during a running burst has no effect.
- R4: A processor start reads the external address at its own edge, even when write control is asserted. If write control is asserted on the next edge with `adv_n_i` = 1, that edge writes the same address.
- R5: A controller start with write control asserted writes `wdata_i` to the external address. With write control negated it reads that address.
- R6: With both start strobes at 1 during a burst, `adv_n_i` = 0 moves to the next burst address. `adv_n_i` = 1 repeats the current address.
- R7: Beat k (counted modulo 4) of a burst from base address B keeps the upper address bits of B. Its low two bits are B[1:0]+k mod 4 when `linear_i` = 1, and B[1:0] XOR k when `linear_i` = 0.
- R8: `gw_n_i` = 0 writes all eight bytes. Otherwise, with `bwe_n_i` = 0, each byte lane i (data bits 8i..8i+7) is written where `bstrb_n_i[i]` = 0. With `bwe_n_i` = 1 the byte strobes have no effect and the cycle is a read.
- R9: Read data appears on `rdata_o` after the edge that captured the address. `rdata_oe_o` is 1 only for such a pipelined read while `oe_n_i` = 0, and follows `oe_n_i` without waiting for a clock.
- R10: `sleep_i` = 1 forces `rdata_oe_o` to 0 at once. An edge with `sleep_i` = 1 ends the burst and performs no access. Memory contents are kept.
- R11: Start strobes on the first two edges after `sleep_i` returns to 0 are ignored and leave memory unchanged. The third edge accepts them.
- R12: When both start strobes are 0 with `ce_n_i` = 0, the processor start wins and the edge is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External word address |
| pstart_n_i | input | 1 | Processor-start burst strobe, active low |
| cstart_n_i | input | 1 | Controller-start burst strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| sel_hi_a_i | input | 1 | Secondary enable, active high |
| sel_hi_b_i | input | 1 | Secondary enable, active high |
| sel_lo_a_n_i | input | 1 | Secondary enable, active low |
| sel_lo_b_n_i | input | 1 | Secondary enable, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| bstrb_n_i | input | 8 | Byte-lane write strobes, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| rdata_oe_o | output | 1 | Data-out enable |

## Verification
Synchronous effects are due one edge after capture. Inputs are driven at the falling edge and the results of a rising edge are sampled at the next falling edge. At that point `rdata_o` and `rdata_oe_o` must already hold the read captured at that edge, or show no read after a write, a deselect or an ignored strobe. The asynchronous paths (`oe_n_i`, `sleep_i`) are checked 1 ns after the input changes, with no clock edge in between. Writes, and cases that must leave memory alone, are checked by reading the address back, and the result is compared with a reference array held in the bench. Full sweeps read every address as a five-beat burst in both burst orders, so the modulo-4 wrap is checked too.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES   = 8;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BEAT_W  = 2;
  localparam int WAKE_CYC = 2;

  // Which byte lanes a cycle would write; zero means a read cycle.
  function automatic logic [LANES-1:0] lane_enables(input logic gw_n,
                                                    input logic bwe_n,
                                                    input logic [LANES-1:0] strb_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~strb_n;
    else             return '0;
  endfunction

  // Low address bits of beat k for a burst opened at offset start.
  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] k,
                                                    input logic linear);
    return linear ? BEAT_W'(start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/bsram_wake.sv
module bsram_wake
  import bsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic wake_block
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (sleep_i)       left <= CW'(WAKE_CYC);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign wake_block = (left != '0);
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pstart_n_i,
  input  logic              cstart_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic              sel_ok,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bstrb_n_i,
  input  logic              sleep_i,
  input  logic              wake_block,
  input  logic              linear_i,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              p_hit,
  output logic              burst_act
);
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_nx;
  logic              c_hit, start_any, desel, open_ok, cont, wr_req;

  assign lane_we   = lane_enables(gw_n_i, bwe_n_i, bstrb_n_i);
  assign wr_req    = |lane_we;

  assign p_hit     = !pstart_n_i && !ce_n_i && !sleep_i && !wake_block;
  assign c_hit     = !cstart_n_i && !sleep_i && !wake_block && !p_hit;
  assign start_any = p_hit || c_hit;
  assign desel     = sleep_i || (c_hit && ce_n_i) || (start_any && !sel_ok);
  assign open_ok   = start_any && !desel;
  assign cont      = burst_act && !start_any && !sleep_i;
  assign beat_nx   = adv_n_i ? beat : BEAT_W'(beat + 1'b1);

  always_comb begin
    acc_addr = addr_i;
    if (!open_ok)
      acc_addr = {base[ADDR_W-1:BEAT_W], beat_offset(base[BEAT_W-1:0], beat_nx, linear_i)};
  end

  assign acc_rd = (open_ok && (p_hit || !wr_req)) || (cont && !wr_req);
  assign acc_wr = (open_ok && c_hit && wr_req) || (cont && wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      base      <= '0;
      beat      <= '0;
    end else if (open_ok) begin
      burst_act <= 1'b1;
      base      <= addr_i;
      beat      <= '0;
    end else if (desel) begin
      burst_act <= 1'b0;
    end else if (cont) begin
      beat      <= beat_nx;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pstart_n_i,
  input  logic              cstart_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic              sel_hi_a_i,
  input  logic              sel_hi_b_i,
  input  logic              sel_lo_a_n_i,
  input  logic              sel_lo_b_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bstrb_n_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              linear_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  // Named internal events, observed by the bound checker.
  logic              acc_rd, acc_wr, p_hit, burst_act, wake_block, rd_valid, sel_ok;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;

  assign sel_ok = sel_hi_a_i && sel_hi_b_i && !sel_lo_a_n_i && !sel_lo_b_n_i;

  bsram_wake u_wake (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wake_block(wake_block)
  );

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .pstart_n_i(pstart_n_i), .cstart_n_i(cstart_n_i), .adv_n_i(adv_n_i),
    .ce_n_i(ce_n_i), .sel_ok(sel_ok), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i),
    .bstrb_n_i(bstrb_n_i), .sleep_i(sleep_i), .wake_block(wake_block),
    .linear_i(linear_i), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .lane_we(lane_we), .p_hit(p_hit), .burst_act(burst_act)
  );

  bsram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd(acc_rd), .wr(acc_wr), .addr(acc_addr),
    .lane_we(lane_we), .wdata(wdata_i), .rdata(rdata_o), .rd_valid(rd_valid)
  );

  assign rdata_oe_o = rd_valid && !oe_n_i && !sleep_i;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic pstart_n_i,
  input logic cstart_n_i,
  input logic ce_n_i,
  input logic sleep_i,
  input logic rdata_oe_o,
  input logic acc_rd,
  input logic acc_wr,
  input logic p_hit,
  input logic burst_act,
  input logic wake_block,
  input logic rd_valid
);
  // R2: masked processor start with nothing running causes no access
  a_r2_pstart_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstart_n_i && ce_n_i && cstart_n_i && !burst_act) |-> (!acc_rd && !acc_wr));

  // R4: a processor start never writes at its own edge
  a_r4_pstart_reads: assert property (@(posedge clk) disable iff (!rst_n)
    p_hit |-> !acc_wr);

  // R5: one access kind per edge
  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr));

  // R9: read data valid one edge after the read
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);

  // R10: sleep silences the output and ends the burst
  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !rdata_oe_o);
  a_r10_sleep_ends: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !burst_act);

  // R11: no access inside the post-sleep window
  a_r11_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
    wake_block |-> (!acc_rd && !acc_wr));
endmodule

bind burst_sram_model burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pstart_n_i(pstart_n_i), .cstart_n_i(cstart_n_i),
  .ce_n_i(ce_n_i), .sleep_i(sleep_i), .rdata_oe_o(rdata_oe_o),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .p_hit(p_hit), .burst_act(burst_act),
  .wake_block(wake_block), .rd_valid(rd_valid)
);

// File: tb/burst_sram_model_tb.sv
`timescale 1ns/1ps
module burst_sram_model_tb;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic pstart_n, cstart_n, adv_n, ce_n, sha, shb, sla_n, slb_n;
  logic gw_n, bwe_n, oe_n, sleep, linear;
  logic [7:0] strb_n;
  logic [63:0] wdata, rdata;
  logic rdata_oe;

  logic [63:0] ref_mem [NW];
  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  burst_sram_model #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .pstart_n_i(pstart_n),
    .cstart_n_i(cstart_n), .adv_n_i(adv_n), .ce_n_i(ce_n),
    .sel_hi_a_i(sha), .sel_hi_b_i(shb), .sel_lo_a_n_i(sla_n), .sel_lo_b_n_i(slb_n),
    .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bstrb_n_i(strb_n), .oe_n_i(oe_n),
    .sleep_i(sleep), .linear_i(linear), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [63:0] pat(input int a);
    return {8{a[7:0]}} ^ 64'hA5C3_5A3C_0F1E_E1F0 ^ (64'(a) << 17);
  endfunction

  function automatic int beat_addr(input int b, input int k, input int lin);
    int lo;
    lo = lin ? (b % 4 + k) % 4 : ((b % 4) ^ (k % 4));
    return (b / 4) * 4 + lo;
  endfunction

  task automatic idle();
    pstart_n = 1; cstart_n = 1; adv_n = 1; ce_n = 0;
    sha = 1; shb = 1; sla_n = 0; slb_n = 0;
    gw_n = 1; bwe_n = 1; strb_n = 8'hFF; oe_n = 0; sleep = 0;
    wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_oe(input string tag, input logic exp);
    tests++;
    if (rdata_oe !== exp) begin
      fails++;
      $display("FAIL %s: rdata_oe act=%0b exp=%0b", tag, rdata_oe, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input int a);
    tests++;
    if (rdata_oe !== 1'b1 || rdata !== ref_mem[a]) begin
      fails++;
      $display("FAIL %s: addr %0d act=%h/oe%0b exp=%h/oe1", tag, a, rdata, rdata_oe, ref_mem[a]);
    end
  endtask

  // Controller-start read of one address, checked next sample.
  task automatic read_one(input string tag, input int a);
    idle(); cstart_n = 0; addr = AW'(a); tick(); chk_rd(tag, a); idle();
  endtask

  initial begin
    idle(); addr = '0; linear = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_oe("R1 reset", 0);
    adv_n = 0; tick();
    chk_oe("R1 no burst before start", 0);

    // R5 R6: fill memory with linear controller-start write bursts
    for (int b = 0; b < NW; b += 4) begin
      idle(); cstart_n = 0; gw_n = 0; addr = AW'(b); wdata = pat(b);
      ref_mem[b] = pat(b);
      tick();
      if (b == 0) chk_oe("R5 write gives no read", 0);
      for (int k = 1; k < 4; k++) begin
        idle(); adv_n = 0; gw_n = 0; wdata = pat(b + k);
        ref_mem[b + k] = pat(b + k);
        tick();
      end
    end
    idle();

    // R7 R9: read every base address in both orders, five beats to see the wrap
    for (int lin = 0; lin < 2; lin++) begin
      for (int b = 0; b < NW; b++) begin
        idle(); linear = lin[0];
        if (b % 2 == 0) pstart_n = 0; else cstart_n = 0;
        addr = AW'(b); tick();
        chk_rd("R9 first beat", b);
        for (int k = 1; k < 5; k++) begin
          idle(); adv_n = 0; tick();
          chk_rd(lin ? "R7 linear beat" : "R7 interleaved beat", beat_addr(b, k, lin));
        end
      end
    end
    idle(); linear = 1;

    // R6: suspend repeats address
    idle(); cstart_n = 0; addr = 8'd140; tick(); chk_rd("R6 open", 140);
    idle(); tick(); chk_rd("R6 suspend 1", 140);
    idle(); tick(); chk_rd("R6 suspend 2", 140);
    idle(); adv_n = 0; tick(); chk_rd("R6 advance", 141);

    // R4: processor start reads, then converts to a write at the same address
    idle(); pstart_n = 0; gw_n = 0; wdata = 64'hDEAD; addr = 8'd100; tick();
    chk_rd("R4 pstart reads despite write control", 100);
    idle(); gw_n = 0; wdata = 64'h1234_5678_9ABC_DEF0; tick();
    ref_mem[100] = 64'h1234_5678_9ABC_DEF0;
    chk_oe("R4 convert edge is a write", 0);
    idle(); tick(); chk_rd("R4 same address written", 100);

    // R8: byte lanes
    for (int i = 0; i < 8; i++) begin
      idle(); cstart_n = 0; bwe_n = 0; strb_n = ~(8'd1 << i);
      addr = AW'(110 + i); wdata = '1;
      ref_mem[110 + i][i*8 +: 8] = 8'hFF;
      tick(); chk_oe("R8 lane write", 0);
      read_one("R8 lane readback", 110 + i);
    end
    idle(); cstart_n = 0; bwe_n = 0; strb_n = 8'h5A; addr = 8'd118; wdata = '0;
    for (int i = 0; i < 8; i++) if (!strb_n[i]) ref_mem[118][i*8 +: 8] = 8'h00;
    tick(); read_one("R8 mixed lanes", 118);
    idle(); cstart_n = 0; bwe_n = 1; strb_n = 8'h00; addr = 8'd120; wdata = '0;
    tick(); chk_rd("R8 strobes ignored without bwe", 120);
    read_one("R8 unchanged", 120);

    // R2: masked processor start, controller-start deselect
    idle(); tick(); tick();
    idle(); cstart_n = 0; ce_n = 1; tick(); chk_oe("R2 deselect", 0);
    idle(); pstart_n = 0; ce_n = 1; addr = 8'd50; tick(); chk_oe("R2 pstart masked", 0);
    idle(); adv_n = 0; tick(); chk_oe("R2 no burst from masked pstart", 0);
    idle(); cstart_n = 0; addr = 8'd60; tick(); chk_rd("R2 open", 60);
    idle(); cstart_n = 0; ce_n = 1; tick(); chk_oe("R2 cstart deselects", 0);
    idle(); adv_n = 0; tick(); chk_oe("R2 burst ended", 0);

    // R3: secondary enables
    idle(); cstart_n = 0; sha = 0; addr = 8'd40; tick(); chk_oe("R3 sel_hi_a off", 0);
    idle(); pstart_n = 0; slb_n = 1; addr = 8'd40; tick(); chk_oe("R3 sel_lo_b off", 0);
    idle(); adv_n = 0; tick(); chk_oe("R3 no burst", 0);
    idle(); cstart_n = 0; addr = 8'd40; tick(); chk_rd("R3 open", 40);
    idle(); adv_n = 0; sha = 0; shb = 0; sla_n = 1; slb_n = 1; tick();
    chk_rd("R3 ignored mid-burst", 41);

    // R12: both strobes, processor start wins
    idle(); pstart_n = 0; cstart_n = 0; gw_n = 0; wdata = '0; addr = 8'd90; tick();
    chk_rd("R12 pstart priority", 90);
    idle(); tick(); read_one("R12 memory unchanged", 90);

    // R9: asynchronous output enable
    idle(); cstart_n = 0; oe_n = 1; addr = 8'd130; tick();
    chk_oe("R9 oe_n high hides data", 0);
    oe_n = 0; #1; chk_rd("R9 oe_n low shows data", 130);

    // R10: sleep
    @(negedge clk);
    idle(); cstart_n = 0; addr = 8'd70; tick(); chk_rd("R10 open", 70);
    idle(); sleep = 1; #1; chk_oe("R10 async off", 0);
    @(negedge clk); tick();
    idle(); adv_n = 0; tick(); chk_oe("R10 burst ended", 0);
    idle(); tick(); tick();

    // R11: post-sleep exclusion window
    idle(); sleep = 1; tick();
    idle(); cstart_n = 0; gw_n = 0; wdata = '1; addr = 8'd80; tick();
    chk_oe("R11 edge 1 ignored", 0);
    idle(); pstart_n = 0; addr = 8'd80; tick();
    chk_oe("R11 edge 2 ignored", 0);
    idle(); pstart_n = 0; addr = 8'd80; tick();
    chk_rd("R11 edge 3 accepted, memory kept", 80);
    read_one("R10 contents kept", 71);

    idle(); tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule